// File: doc/BRIEF.md
# SIMD Lane Divergence Reconvergence Stack

This block holds the active-lane mask of an N-lane SIMD core and implements the two control-flow markers that let a predicated branch send some lanes one way and the rest the other way. A split marker narrows the mask to the lanes whose predicate is true. It records two stack entries: one that later brings back the lanes left behind, and one that later restores the mask that was in effect before the split. The matching join marker is reached twice. The first time, the PC is sent back to the instruction after the split with the opposite lanes enabled. The second time, control falls through with the old mask. Splits may nest up to the stack depth.

The block also gates ordinary instructions per lane: a lane executes only when it is in the mask and, for a predicated instruction, its predicate bit is set. For control-flow instructions it raises a divergence flag when only part of the active lanes would take the branch. Mask, stack and flag updates are registered. They appear on the clock edge that samples the strobe, and the PC redirect is a single-cycle pulse.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the lane mask is 1 (only lane 0 enabled) and the stack is empty. The redirect, divergence, overflow and underflow outputs are all low.
- R2: A split with at least two free stack entries loads the lane mask with pred_i on the next clock edge, whatever the current mask.
- R3: The first join after a split drives redirect_o high for exactly one cycle, with redirect_pc_o equal to the ret_pc_i given with that split. On the same edge the mask becomes the bitwise complement of that split's pred_i.
- R4: The second join after a split leaves redirect_o low and restores the mask that was in effect before the split.
- R5: Nested splits unwind in last-in-first-out order. Each join pops exactly one entry.
- R6: On cf_chk_i, let T = mask AND (pred_use_i ? pred_i : all ones). diverge_o is high on the next cycle exactly when T is nonzero and T differs from the mask.
- R7: lane_exec_o equals the mask AND (pred_use_i ? pred_i : all ones), combinationally.
- R8: A split with fewer than two free entries pulses ovf_o for one cycle. It leaves the mask and the stack unchanged, so later joins see the earlier entries.
- R9: A join on an empty stack pulses udf_o for one cycle, keeps redirect_o low and leaves the mask unchanged.
- R10: Split and join act even when the current mask is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| split_i | input | 1 | Decoded split strobe |
| join_i | input | 1 | Decoded join strobe (never with split_i) |
| pred_i | input | LANES | Per-lane bits of the selected predicate register |
| pred_use_i | input | 1 | Current instruction is predicated |
| ret_pc_i | input | PC_W | Address of the instruction after the split |
| cf_chk_i | input | 1 | Current instruction is a control-flow instruction |
| lane_mask_o | output | LANES | Current active-lane mask |
| lane_exec_o | output | LANES | Per-lane execute enable for ordinary instructions |
| redirect_o | output | 1 | One-cycle PC redirect |
| redirect_pc_o | output | PC_W | Redirect target |
| diverge_o | output | 1 | Divergent-branch exception pulse |
| ovf_o | output | 1 | Stack overflow pulse |
| udf_o | output | 1 | Stack underflow pulse |

## Verification
The bench builds the block with four lanes, a four-entry stack and 8-bit PCs. With four lanes, every mask value, every predicate value and both predicated and unpredicated forms can be swept in full. Each of the 16 split masks is tested against all 16 predicates for the execute enables and for divergence, and each split is then unwound through both joins. With four stack entries, two nested splits fill the stack, so a third split reaches overflow. Unwinding that nest then reaches underflow, and the same sequence covers splits and joins issued while the mask is all zero.

// File: rtl/reconv_pkg.sv
package reconv_pkg;

   typedef enum logic [1:0] {
      STK_HOLD  = 2'd0,
      STK_PUSH2 = 2'd1,
      STK_POP   = 2'd2
   } stk_op_e;

   localparam int DIV_BY_COUNT  = 0;
   localparam int DIV_BY_SUBSET = 1;

endpackage

// File: rtl/reconv_lifo.sv
module reconv_lifo
   import reconv_pkg::*;
#(
   parameter int LANES = 8,
   parameter int DEPTH = 8,
   parameter int PC_W  = 32,
   localparam int DW   = $clog2(DEPTH + 1),
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  stk_op_e          op,
   input  logic [LANES-1:0] lo_mask,
   input  logic [PC_W-1:0]  lo_pc,
   input  logic             lo_ft,
   input  logic [LANES-1:0] hi_mask,
   input  logic [PC_W-1:0]  hi_pc,
   input  logic             hi_ft,
   output logic [LANES-1:0] top_mask,
   output logic [PC_W-1:0]  top_pc,
   output logic             top_ft,
   output logic             empty,
   output logic             room2,
   output logic [DW-1:0]    depth
);

   logic [LANES-1:0] mem_mask [DEPTH];
   logic [PC_W-1:0]  mem_pc   [DEPTH];
   logic             mem_ft   [DEPTH];
   logic [DW-1:0]    sp_q;
   logic [AW-1:0]    wr_lo_idx;
   logic [AW-1:0]    wr_hi_idx;
   logic [AW-1:0]    rd_idx;

   assign empty     = (sp_q == '0);
   assign room2     = (sp_q <= DW'(DEPTH - 2));
   assign depth     = sp_q;
   assign wr_lo_idx = AW'(sp_q);
   assign wr_hi_idx = AW'(sp_q + DW'(1));
   assign rd_idx    = empty ? '0 : AW'(sp_q - DW'(1));

   assign top_mask  = mem_mask[rd_idx];
   assign top_pc    = mem_pc[rd_idx];
   assign top_ft    = mem_ft[rd_idx];

   always_ff @(posedge clk) begin
      if (op == STK_PUSH2) begin
         mem_mask[wr_lo_idx] <= lo_mask;
         mem_pc[wr_lo_idx]   <= lo_pc;
         mem_ft[wr_lo_idx]   <= lo_ft;
         mem_mask[wr_hi_idx] <= hi_mask;
         mem_pc[wr_hi_idx]   <= hi_pc;
         mem_ft[wr_hi_idx]   <= hi_ft;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q <= '0;
      end else begin
         unique case (op)
            STK_PUSH2: sp_q <= sp_q + DW'(2);
            STK_POP:   sp_q <= sp_q - DW'(1);
            default:   sp_q <= sp_q;
         endcase
      end
   end

endmodule

// File: rtl/reconv_diverge.sv
module reconv_diverge
   import reconv_pkg::*;
#(
   parameter int LANES = 8,
   parameter int STYLE = DIV_BY_COUNT
) (
   input  logic [LANES-1:0] mask,
   input  logic [LANES-1:0] pred,
   input  logic             pred_use,
   output logic             split_dir
);

   logic [LANES-1:0] taking;

   assign taking = mask & (pred_use ? pred : {LANES{1'b1}});

   generate
      if (STYLE == DIV_BY_COUNT) begin : g_count
         int n_take;
         int n_live;
         always_comb begin
            n_take    = $countones(taking);
            n_live    = $countones(mask);
            split_dir = (n_take != 0) && (n_take != n_live);
         end
      end else begin : g_subset
         assign split_dir = (|taking) && (taking != mask);
      end
   endgenerate

endmodule

// File: rtl/reconv_lane_gate.sv
module reconv_lane_gate #(
   parameter int LANES = 8
) (
   input  logic [LANES-1:0] mask,
   input  logic [LANES-1:0] pred,
   input  logic             pred_use,
   output logic [LANES-1:0] exec_en
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign exec_en[g] = mask[g] & (pred[g] | ~pred_use);
   end

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
   import reconv_pkg::*;
#(
   parameter int LANES     = 8,
   parameter int DEPTH     = 8,
   parameter int PC_W      = 32,
   parameter int DIV_STYLE = DIV_BY_COUNT,
   localparam int DW       = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             split_i,
   input  logic             join_i,
   input  logic [LANES-1:0] pred_i,
   input  logic             pred_use_i,
   input  logic [PC_W-1:0]  ret_pc_i,
   input  logic             cf_chk_i,
   output logic [LANES-1:0] lane_mask_o,
   output logic [LANES-1:0] lane_exec_o,
   output logic             redirect_o,
   output logic [PC_W-1:0]  redirect_pc_o,
   output logic             diverge_o,
   output logic             ovf_o,
   output logic             udf_o
);

   if (LANES < 1) begin : g_bad_lanes
      $error("simt_reconv_stack: LANES must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("simt_reconv_stack: DEPTH must hold one split (2 entries)");
   end
   if (PC_W < 1) begin : g_bad_pc
      $error("simt_reconv_stack: PC_W must be at least 1");
   end
   if (DIV_STYLE != DIV_BY_COUNT && DIV_STYLE != DIV_BY_SUBSET) begin : g_bad_style
      $error("simt_reconv_stack: unknown DIV_STYLE");
   end

   localparam logic [LANES-1:0] RESET_MASK = LANES'(1);

   logic [LANES-1:0] mask_q;
   logic             redir_q;
   logic [PC_W-1:0]  redir_pc_q;
   logic             div_q;
   logic             ovf_q;
   logic             udf_q;

   stk_op_e          op;
   logic [LANES-1:0] top_mask;
   logic [PC_W-1:0]  top_pc;
   logic             top_ft;
   logic             stk_empty;
   logic             stk_room2;
   logic [DW-1:0]    stk_depth;
   logic             split_ok;
   logic             join_ok;
   logic             div_now;

   assign split_ok = split_i & stk_room2;
   assign join_ok  = join_i & ~stk_empty;

   always_comb begin
      op = STK_HOLD;
      if (split_ok)     op = STK_PUSH2;
      else if (join_ok) op = STK_POP;
   end

   // Lower entry restores the pre-split mask; upper entry resumes the other lanes.
   reconv_lifo #(
      .LANES (LANES),
      .DEPTH (DEPTH),
      .PC_W  (PC_W)
   ) lifo_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .lo_mask  (mask_q),
      .lo_pc    (ret_pc_i),
      .lo_ft    (1'b1),
      .hi_mask  (~pred_i),
      .hi_pc    (ret_pc_i),
      .hi_ft    (1'b0),
      .top_mask (top_mask),
      .top_pc   (top_pc),
      .top_ft   (top_ft),
      .empty    (stk_empty),
      .room2    (stk_room2),
      .depth    (stk_depth)
   );

   reconv_diverge #(
      .LANES (LANES),
      .STYLE (DIV_STYLE)
   ) div_i (
      .mask      (mask_q),
      .pred      (pred_i),
      .pred_use  (pred_use_i),
      .split_dir (div_now)
   );

   reconv_lane_gate #(
      .LANES (LANES)
   ) gate_i (
      .mask     (mask_q),
      .pred     (pred_i),
      .pred_use (pred_use_i),
      .exec_en  (lane_exec_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q     <= RESET_MASK;
         redir_q    <= 1'b0;
         redir_pc_q <= '0;
         div_q      <= 1'b0;
         ovf_q      <= 1'b0;
         udf_q      <= 1'b0;
      end else begin
         redir_q <= 1'b0;
         div_q   <= cf_chk_i & div_now;
         ovf_q   <= split_i & ~stk_room2;
         udf_q   <= join_i & stk_empty;
         if (split_ok) begin
            mask_q <= pred_i;
         end else if (join_ok) begin
            mask_q <= top_mask;
            if (!top_ft) begin
               redir_q    <= 1'b1;
               redir_pc_q <= top_pc;
            end
         end
      end
   end

   assign lane_mask_o   = mask_q;
   assign redirect_o    = redir_q;
   assign redirect_pc_o = redir_pc_q;
   assign diverge_o     = div_q;
   assign ovf_o         = ovf_q;
   assign udf_o         = udf_q;

endmodule

// File: rtl/reconv_stack_chk.sv
module reconv_stack_chk #(
   parameter int LANES = 8,
   parameter int DEPTH = 8,
   parameter int PC_W  = 32,
   localparam int DW   = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             split_i,
   input logic             join_i,
   input logic [LANES-1:0] pred_i,
   input logic [LANES-1:0] lane_mask_o,
   input logic             redirect_o,
   input logic             ovf_o,
   input logic             udf_o,
   input logic [DW-1:0]    stk_depth
);

   // R2
   split_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (split_i && int'(stk_depth) <= DEPTH - 2) |=> lane_mask_o == $past(pred_i));

   // R3
   redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |=> !redirect_o);

   // R3
   redirect_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> $past(join_i));

   // R5
   pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (join_i && !split_i && stk_depth != '0) |=> int'(stk_depth) == int'($past(stk_depth)) - 1);

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> (stk_depth == $past(stk_depth)) && (lane_mask_o == $past(lane_mask_o)));

   // R9
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      udf_o |-> (lane_mask_o == $past(lane_mask_o)) && !redirect_o);

   // R8
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ovf_o, udf_o, redirect_o}));

endmodule

bind simt_reconv_stack reconv_stack_chk #(
   .LANES (LANES),
   .DEPTH (DEPTH),
   .PC_W  (PC_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .split_i     (split_i),
   .join_i      (join_i),
   .pred_i      (pred_i),
   .lane_mask_o (lane_mask_o),
   .redirect_o  (redirect_o),
   .ovf_o       (ovf_o),
   .udf_o       (udf_o),
   .stk_depth   (stk_depth)
);

// File: tb/simt_reconv_stack_tb_top.sv
module simt_reconv_stack_tb_top;

   localparam int LANES = 4;
   localparam int DEPTH = 4;
   localparam int PC_W  = 8;
   localparam logic [LANES-1:0] ALL = '1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             split_i = 1'b0;
   logic             join_i = 1'b0;
   logic [LANES-1:0] pred_i = '0;
   logic             pred_use_i = 1'b0;
   logic [PC_W-1:0]  ret_pc_i = '0;
   logic             cf_chk_i = 1'b0;
   logic [LANES-1:0] lane_mask_o;
   logic [LANES-1:0] lane_exec_o;
   logic             redirect_o;
   logic [PC_W-1:0]  redirect_pc_o;
   logic             diverge_o;
   logic             ovf_o;
   logic             udf_o;

   int checks = 0;
   int errors = 0;
   logic [LANES-1:0] exec_seen;

   always #10 clk = ~clk;

   simt_reconv_stack #(
      .LANES (LANES),
      .DEPTH (DEPTH),
      .PC_W  (PC_W)
   ) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .split_i       (split_i),
      .join_i        (join_i),
      .pred_i        (pred_i),
      .pred_use_i    (pred_use_i),
      .ret_pc_i      (ret_pc_i),
      .cf_chk_i      (cf_chk_i),
      .lane_mask_o   (lane_mask_o),
      .lane_exec_o   (lane_exec_o),
      .redirect_o    (redirect_o),
      .redirect_pc_o (redirect_pc_o),
      .diverge_o     (diverge_o),
      .ovf_o         (ovf_o),
      .udf_o         (udf_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Drive one cycle of stimulus, capture the gate output before the edge,
   // then sample registered outputs 5 ns after the edge.
   task automatic cyc(input bit sp, input bit jn, input logic [LANES-1:0] p,
                      input bit use_p, input logic [PC_W-1:0] pc, input bit cf);
      split_i    = sp;
      join_i     = jn;
      pred_i     = p;
      pred_use_i = use_p;
      ret_pc_i   = pc;
      cf_chk_i   = cf;
      #1;
      exec_seen = lane_exec_o;
      @(posedge clk);
      #5;
      split_i  = 1'b0;
      join_i   = 1'b0;
      cf_chk_i = 1'b0;
   endtask

   task automatic expect_state(input string req, input logic [LANES-1:0] m,
                               input bit rd, input bit ov, input bit ud);
      chk(lane_mask_o == m, req, int'(lane_mask_o), int'(m));
      chk(redirect_o == rd, req, int'(redirect_o), int'(rd));
      chk(ovf_o == ov, req, int'(ovf_o), int'(ov));
      chk(udf_o == ud, req, int'(udf_o), int'(ud));
   endtask

   initial begin
      #(20 * 190000);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #5;
      rst_n = 1'b1;
      // R1 reset state
      expect_state("R1", 4'b0001, 1'b0, 1'b0, 1'b0);
      chk(diverge_o == 1'b0, "R1", int'(diverge_o), 0);

      // R9 join with empty stack
      cyc(1'b0, 1'b1, '0, 1'b0, 8'h00, 1'b0);
      expect_state("R9", 4'b0001, 1'b0, 1'b0, 1'b1);
      cyc(1'b0, 1'b0, '0, 1'b0, 8'h00, 1'b0);
      chk(udf_o == 1'b0, "R9", int'(udf_o), 0);

      for (int p = 0; p < 16; p++) begin
         logic [PC_W-1:0] rpc;
         rpc = PC_W'(p * 3 + 5);
         cyc(1'b1, 1'b0, LANES'(p), 1'b1, rpc, 1'b0);
         expect_state("R2", LANES'(p), 1'b0, 1'b0, 1'b0);
         for (int q = 0; q < 16; q++) begin
            for (int u = 0; u < 2; u++) begin
               logic [LANES-1:0] take;
               bit dexp;
               take = LANES'(p) & ((u == 1) ? LANES'(q) : ALL);
               dexp = (take != '0) && (take != LANES'(p));
               cyc(1'b0, 1'b0, LANES'(q), u[0], 8'h00, 1'b1);
               chk(exec_seen == take, "R7", int'(exec_seen), int'(take));
               chk(diverge_o == dexp, "R6", int'(diverge_o), int'(dexp));
            end
         end
         cyc(1'b0, 1'b1, '0, 1'b0, 8'h00, 1'b0);
         expect_state("R3", ~LANES'(p), 1'b1, 1'b0, 1'b0);
         chk(redirect_pc_o == rpc, "R3", int'(redirect_pc_o), int'(rpc));
         cyc(1'b0, 1'b0, '0, 1'b0, 8'h00, 1'b0);
         chk(redirect_o == 1'b0, "R3", int'(redirect_o), 0);
         cyc(1'b0, 1'b1, '0, 1'b0, 8'h00, 1'b0);
         expect_state("R4", 4'b0001, 1'b0, 1'b0, 1'b0);
      end

      // Nested splits, overflow, zero-mask operation, unwinding
      cyc(1'b1, 1'b0, 4'b0000, 1'b1, 8'h10, 1'b0);
      expect_state("R2", 4'b0000, 1'b0, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 4'b1010, 1'b1, 8'h20, 1'b0);
      expect_state("R10", 4'b1010, 1'b0, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 4'b1111, 1'b1, 8'h30, 1'b0);
      expect_state("R8", 4'b1010, 1'b0, 1'b1, 1'b0);
      cyc(1'b0, 1'b1, '0, 1'b0, 8'h00, 1'b0);
      expect_state("R5", 4'b0101, 1'b1, 1'b0, 1'b0);
      chk(redirect_pc_o == 8'h20, "R5", int'(redirect_pc_o), 'h20);
      cyc(1'b0, 1'b1, '0, 1'b0, 8'h00, 1'b0);
      expect_state("R5", 4'b0000, 1'b0, 1'b0, 1'b0);
      cyc(1'b0, 1'b1, '0, 1'b0, 8'h00, 1'b0);
      expect_state("R10", 4'b1111, 1'b1, 1'b0, 1'b0);
      chk(redirect_pc_o == 8'h10, "R8", int'(redirect_pc_o), 'h10);
      cyc(1'b0, 1'b1, '0, 1'b0, 8'h00, 1'b0);
      expect_state("R4", 4'b0001, 1'b0, 1'b0, 1'b0);
      cyc(1'b0, 1'b1, '0, 1'b0, 8'h00, 1'b0);
      expect_state("R9", 4'b0001, 1'b0, 1'b0, 1'b1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule